// File: doc/BRIEF.md
# Shock-Tolerant Audio Buffer Controller

This block sequences a circular audio buffer kept in external memory so that playback survives mechanical shocks to a disc drive. Audio nibbles arrive faster than they are played, so the buffer normally runs ahead of the read side. When any qualified shock source fires, writing freezes and playback drains the stored audio. When the host signals that the disc position has been found again, the write address returns to the checkpoint taken at the last subcode-frame boundary. New audio then continues from the last good sample.

The controller owns the read and write nibble pointers, the write checkpoint and the replay base. It derives full and empty from the pointers. A host-side command decoder supplies level flags and single-cycle command pulses. The memory timing generator and the serial audio ports sit outside and follow `wr_en`, `rd_en` and the two pointers.

Top module: `shock_buf_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `state_o` is 0, both pointers are 0 and `shock_det` is 0. The cycle after that, `state_o` is 6.
- R2: `state_o` uses this encoding: 0 idle/cleared, 1 fill, 2 refill after resume, 4 hold, 5 resume, 6 waiting for the first nibble, 7 shock. Code 3 never appears. State 6 moves to 1 on its first accepted write.
- R3: `fill_en` is high only in states 1, 2 and 6 while the buffer is not full. A write (`wr_en`) is accepted when `fill_en` and `wr_req` are both high, and it advances `wr_ptr` by one with wrap.
- R4: `full` is high when `wr_ptr`+1 (wrapped) equals `rd_ptr`. In states 1 or 2, a full buffer moves the controller to hold (4) on the next edge. `hold` is high in state 4.
- R5: In states 1, 2, 4 and 6, any qualified shock source moves the controller to state 7 on the next edge, and `shock_det` is high exactly in state 7. Shock entry takes priority over the full and resume transitions.
- R6: The shock sources are qualified as follows. `track_det` counts only while `cmd_jump_busy` is low. `rot_shock` counts only while `cmd_rot_en` is high. A missed frame (`synth_frame` without `frame_pulse`) counts only until `status_read` has been seen while `full` is high. That mask clears on resume or on a return to state 0. `cmd_host_shock` always counts.
- R7: In states 1 and 2, a frame boundary (`frame_pulse` or `synth_frame`) saves the current `wr_ptr` as the checkpoint. A `cmd_pfb` pulse in state 4 or 7 moves the controller to 5 and then to 2, with `wr_ptr` reloaded to the checkpoint. State 2 returns to 1 on the next frame boundary.
- R8: `cmd_flush`, or `bypass` held high, forces state 0 on the next edge and clears both pointers. `bypass` holds the controller in state 0. After `bypass` is released, the controller goes through 6 with an empty buffer.
- R9: In state 7, if the buffer is empty, `cmd_echo` is low and `cmd_pfb` is not pulsed, the next state is 0 and the pointers are cleared.
- R10: `empty` is high when the pointers are equal. `rd_en` equals `rd_req` and not `empty`, and it advances `rd_ptr` by one with wrap.
- R11: In states 4 and 7, with `cmd_echo` high, a read request on an empty buffer reloads `rd_ptr` with the replay base. The replay base is the `rd_ptr` value held when the controller entered 4 or 7 from another state.
- R12: Both pointers wrap from DEPTH_L-1 to 0 when `large_mem` is high, and from DEPTH_S-1 to 0 when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| large_mem | input | 1 | Selects the large memory wrap point |
| bypass | input | 1 | Bypass/power-down; holds the controller cleared |
| cmd_flush | input | 1 | Flush command pulse |
| cmd_pfb | input | 1 | Position-found-back command pulse |
| cmd_host_shock | input | 1 | Host-detected shock flag |
| cmd_jump_busy | input | 1 | Jump in progress; masks the track detector |
| cmd_rot_en | input | 1 | Enables rotational shock detection |
| cmd_echo | input | 1 | Replay the buffer when it runs dry |
| status_read | input | 1 | Host reads the status word this cycle |
| track_det | input | 1 | Off-track detector, active high |
| rot_shock | input | 1 | Decoder rolled out of its internal buffer |
| frame_pulse | input | 1 | Decoded subcode-frame pulse |
| synth_frame | input | 1 | Regenerated subcode-frame pulse |
| wr_req | input | 1 | Input nibble available |
| rd_req | input | 1 | Output nibble demanded |
| state_o | output | 3 | Controller state code |
| shock_det | output | 1 | Shock mode active |
| fill_en | output | 1 | Writing permitted |
| wr_en | output | 1 | Nibble written at wr_ptr this cycle |
| rd_en | output | 1 | Nibble read at rd_ptr this cycle |
| full | output | 1 | Buffer full |
| empty | output | 1 | Buffer empty |
| hold | output | 1 | Hold mode active |
| wr_ptr | output | PTR_W | Write nibble address |
| rd_ptr | output | PTR_W | Read nibble address |

## Verification
The assertions assume that `large_mem` changes only in a cycle where flush or bypass is also asserted, so the wrap point never moves under live pointers. They also assume the command pulses last one cycle, and that a restored checkpoint can sit behind the read pointer without breaking the pointer bounds. The bench changes `large_mem` only together with a flush. It normally drives `frame_pulse` and `synth_frame` together, and separates them only to model a missed frame. Directed phases reach hold, every shock source with and without its mask, echo replay, drain-to-idle and both wrap points. A long pseudo-random phase then mixes all inputs under those same rules.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_FILL   = 3'd1,
      ST_REFILL = 3'd2,
      ST_SPARE  = 3'd3,
      ST_HOLD   = 3'd4,
      ST_RESUME = 3'd5,
      ST_FIRST  = 3'd6,
      ST_SHOCK  = 3'd7
   } sbc_state_e;
endpackage

// File: rtl/sbc_wrap_inc.sv
// Pointer increment with a run-time selectable wrap point.
module sbc_wrap_inc #(
   parameter int PTR_W   = 20,
   parameter int DEPTH_S = 262144,
   parameter int DEPTH_L = 1048576
) (
   input  logic             large_mem,
   input  logic [PTR_W-1:0] ptr_i,
   output logic [PTR_W-1:0] ptr_o
);
   localparam bit POW2 = ((DEPTH_S & (DEPTH_S - 1)) == 0) && ((DEPTH_L & (DEPTH_L - 1)) == 0);
   localparam logic [PTR_W-1:0] LAST_S = PTR_W'(DEPTH_S - 1);
   localparam logic [PTR_W-1:0] LAST_L = PTR_W'(DEPTH_L - 1);

   generate
      if (POW2) begin : g_mask
         // power-of-two depths: the last address doubles as a mask
         assign ptr_o = (ptr_i + 1'b1) & (large_mem ? LAST_L : LAST_S);
      end else begin : g_cmp
         logic [PTR_W-1:0] last;
         assign last  = large_mem ? LAST_L : LAST_S;
         assign ptr_o = (ptr_i == last) ? '0 : ptr_i + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/sbc_shock_src.sv
// Qualifies the shock sources and keeps the full-flag-read mask.
module sbc_shock_src (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_seen,
   input  logic full,
   input  logic status_read,
   input  logic host_shock,
   input  logic track_det,
   input  logic jump_busy,
   input  logic rot_en,
   input  logic rot_shock,
   input  logic frame_pulse,
   input  logic synth_frame,
   output logic hit
);
   logic full_seen_q;
   logic miss_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    full_seen_q <= 1'b0;
      else if (clr_seen)             full_seen_q <= 1'b0;
      else if (status_read && full)  full_seen_q <= 1'b1;
   end

   assign miss_frame = synth_frame && !frame_pulse && !full_seen_q;
   assign hit = host_shock || (track_det && !jump_busy) || (rot_shock && rot_en) || miss_frame;
endmodule

// File: rtl/shock_buf_ctrl.sv
module shock_buf_ctrl
   import sbc_pkg::*;
#(
   parameter int PTR_W   = 20,
   parameter int DEPTH_S = 262144,
   parameter int DEPTH_L = 1048576
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             large_mem,
   input  logic             bypass,
   input  logic             cmd_flush,
   input  logic             cmd_pfb,
   input  logic             cmd_host_shock,
   input  logic             cmd_jump_busy,
   input  logic             cmd_rot_en,
   input  logic             cmd_echo,
   input  logic             status_read,
   input  logic             track_det,
   input  logic             rot_shock,
   input  logic             frame_pulse,
   input  logic             synth_frame,
   input  logic             wr_req,
   input  logic             rd_req,
   output logic [2:0]       state_o,
   output logic             shock_det,
   output logic             fill_en,
   output logic             wr_en,
   output logic             rd_en,
   output logic             full,
   output logic             empty,
   output logic             hold,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr
);
   generate
      if (DEPTH_S < 4 || DEPTH_L < DEPTH_S) begin : g_bad_depth
         $error("shock_buf_ctrl: depths must satisfy 4 <= DEPTH_S <= DEPTH_L");
      end
      if (DEPTH_L > (2 ** PTR_W)) begin : g_bad_width
         $error("shock_buf_ctrl: PTR_W too narrow for DEPTH_L");
      end
   endgenerate

   sbc_state_e       state_q, st_d;
   logic [PTR_W-1:0] wr_q, rd_q, save_q, base_q;
   logic [PTR_W-1:0] wr_nx, rd_nx;
   logic             hit, boundary, flush_any, echo_reload;
   logic             filling, stalled, into_stall, clr_seen;

   sbc_wrap_inc #(.PTR_W(PTR_W), .DEPTH_S(DEPTH_S), .DEPTH_L(DEPTH_L)) u_wr_inc (
      .large_mem(large_mem), .ptr_i(wr_q), .ptr_o(wr_nx));
   sbc_wrap_inc #(.PTR_W(PTR_W), .DEPTH_S(DEPTH_S), .DEPTH_L(DEPTH_L)) u_rd_inc (
      .large_mem(large_mem), .ptr_i(rd_q), .ptr_o(rd_nx));

   sbc_shock_src u_src (
      .clk(clk), .rst_n(rst_n), .clr_seen(clr_seen), .full(full),
      .status_read(status_read), .host_shock(cmd_host_shock),
      .track_det(track_det), .jump_busy(cmd_jump_busy), .rot_en(cmd_rot_en),
      .rot_shock(rot_shock), .frame_pulse(frame_pulse), .synth_frame(synth_frame),
      .hit(hit));

   assign flush_any   = cmd_flush || bypass;
   assign boundary    = frame_pulse || synth_frame;
   assign full        = (wr_nx == rd_q);
   assign empty       = (wr_q == rd_q);
   assign filling     = (state_q == ST_FILL) || (state_q == ST_REFILL) || (state_q == ST_FIRST);
   assign stalled     = (state_q == ST_HOLD) || (state_q == ST_SHOCK);
   assign fill_en     = filling && !full;
   assign wr_en       = fill_en && wr_req;
   assign rd_en       = rd_req && !empty;
   assign echo_reload = rd_req && empty && cmd_echo && stalled;
   assign into_stall  = ((st_d == ST_HOLD) || (st_d == ST_SHOCK)) && !stalled;
   assign clr_seen    = (st_d == ST_IDLE) || (st_d == ST_RESUME);

   always_comb begin
      st_d = state_q;
      if (flush_any) begin
         st_d = ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE:   st_d = ST_FIRST;
            ST_FIRST:  if (hit) st_d = ST_SHOCK;
                       else if (wr_en) st_d = ST_FILL;
            ST_FILL:   if (hit) st_d = ST_SHOCK;
                       else if (full) st_d = ST_HOLD;
            ST_REFILL: if (hit) st_d = ST_SHOCK;
                       else if (full) st_d = ST_HOLD;
                       else if (boundary) st_d = ST_FILL;
            ST_HOLD:   if (hit) st_d = ST_SHOCK;
                       else if (cmd_pfb) st_d = ST_RESUME;
            ST_SHOCK:  if (cmd_pfb) st_d = ST_RESUME;
                       else if (empty && !cmd_echo) st_d = ST_IDLE;
            ST_RESUME: st_d = ST_REFILL;
            default:   st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= '0;
         rd_q    <= '0;
         save_q  <= '0;
         base_q  <= '0;
      end else begin
         state_q <= st_d;
         if (st_d == ST_IDLE) begin
            wr_q   <= '0;
            rd_q   <= '0;
            save_q <= '0;
            base_q <= '0;
         end else begin
            if (state_q == ST_RESUME) wr_q <= save_q;
            else if (wr_en)           wr_q <= wr_nx;
            if (echo_reload)          rd_q <= base_q;
            else if (rd_en)           rd_q <= rd_nx;
            if ((state_q == ST_FILL || state_q == ST_REFILL) && boundary) save_q <= wr_q;
            if (into_stall)           base_q <= rd_q;
         end
      end
   end

   assign state_o   = state_q;
   assign shock_det = (state_q == ST_SHOCK);
   assign hold      = (state_q == ST_HOLD);
   assign wr_ptr    = wr_q;
   assign rd_ptr    = rd_q;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
   parameter int PTR_W   = 20,
   parameter int DEPTH_S = 262144,
   parameter int DEPTH_L = 1048576
) (
   input logic             clk,
   input logic             rst_n,
   input logic             large_mem,
   input logic             bypass,
   input logic             cmd_flush,
   input logic             cmd_pfb,
   input logic             cmd_host_shock,
   input logic             cmd_echo,
   input logic [2:0]       state_o,
   input logic             shock_det,
   input logic             full,
   input logic             empty,
   input logic [PTR_W-1:0] wr_ptr,
   input logic [PTR_W-1:0] rd_ptr
);
   logic in_active;
   logic live;
   int   depth;
   assign in_active = (state_o == 3'd1) || (state_o == 3'd2) || (state_o == 3'd4) || (state_o == 3'd6);
   assign live      = !bypass && !cmd_flush;
   assign depth     = large_mem ? DEPTH_L : DEPTH_S;

   // R2: the spare code is never reached
   a_r2_no_spare_state: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 3'd3);

   // R4: a full buffer takes no write
   a_r4_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (full && live && state_o != 3'd5) |=> wr_ptr == $past(wr_ptr));

   // R5: host shock in an active state enters shock mode
   a_r5_host_enters_shock: assert property (@(posedge clk) disable iff (!rst_n)
      (live && cmd_host_shock && in_active) |=> shock_det);

   // R8: bypass clears the controller
   a_r8_bypass_clears: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> (state_o == 3'd0 && wr_ptr == '0 && rd_ptr == '0));

   // R9: shock with a drained buffer and no echo returns to idle
   a_r9_drain_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd7 && empty && !cmd_echo && !cmd_pfb) |=> state_o == 3'd0);

   // R10: an empty buffer without echo is not read
   a_r10_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !cmd_echo && live && state_o != 3'd7) |=> rd_ptr == $past(rd_ptr));

   // R12: pointers stay below the selected depth
   a_r12_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(wr_ptr) < depth) && (int'(rd_ptr) < depth));
endmodule

bind shock_buf_ctrl sbc_checker #(.PTR_W(PTR_W), .DEPTH_S(DEPTH_S), .DEPTH_L(DEPTH_L)) u_chk (
   .clk(clk), .rst_n(rst_n), .large_mem(large_mem), .bypass(bypass),
   .cmd_flush(cmd_flush), .cmd_pfb(cmd_pfb), .cmd_host_shock(cmd_host_shock),
   .cmd_echo(cmd_echo), .state_o(state_o), .shock_det(shock_det),
   .full(full), .empty(empty), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr));

// File: tb/shock_buf_ctrl_tb.sv
module shock_buf_ctrl_tb;
   localparam int PTR_W = 8;
   localparam int DS    = 12;
   localparam int DL    = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic large_mem = 0, bypass = 0, cmd_flush = 0, cmd_pfb = 0, cmd_host_shock = 0;
   logic cmd_jump_busy = 0, cmd_rot_en = 0, cmd_echo = 0, status_read = 0;
   logic track_det = 0, rot_shock = 0, frame_pulse = 0, synth_frame = 0, wr_req = 0, rd_req = 0;
   logic [2:0] state_o;
   logic shock_det, fill_en, wr_en, rd_en, full, empty, hold;
   logic [PTR_W-1:0] wr_ptr, rd_ptr;

   int checks = 0;
   int errors = 0;
   // reference model
   int ms = 0, mwr = 0, mrd = 0, msave = 0, mbase = 0;
   bit mseen = 0;

   always #5 clk = ~clk;

   shock_buf_ctrl #(.PTR_W(PTR_W), .DEPTH_S(DS), .DEPTH_L(DL)) u_dut (
      .clk(clk), .rst_n(rst_n), .large_mem(large_mem), .bypass(bypass),
      .cmd_flush(cmd_flush), .cmd_pfb(cmd_pfb), .cmd_host_shock(cmd_host_shock),
      .cmd_jump_busy(cmd_jump_busy), .cmd_rot_en(cmd_rot_en), .cmd_echo(cmd_echo),
      .status_read(status_read), .track_det(track_det), .rot_shock(rot_shock),
      .frame_pulse(frame_pulse), .synth_frame(synth_frame), .wr_req(wr_req),
      .rd_req(rd_req), .state_o(state_o), .shock_det(shock_det), .fill_en(fill_en),
      .wr_en(wr_en), .rd_en(rd_en), .full(full), .empty(empty), .hold(hold),
      .wr_ptr(wr_ptr), .rd_ptr(rd_ptr));

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int mnext(int p);
      int d = large_mem ? DL : DS;
      return (p + 1 == d) ? 0 : p + 1;
   endfunction

   // one clock: compare outputs with the model, advance the model
   task automatic step();
      bit mfull, mempty, filling, stalled, wrok, rdok, reload, hit, bnd;
      int ns, nwr, nrd, nsave, nbase;
      #1;
      mfull   = (mnext(mwr) == mrd);
      mempty  = (mwr == mrd);
      filling = (ms == 1 || ms == 2 || ms == 6);
      stalled = (ms == 4 || ms == 7);
      wrok    = filling && !mfull && wr_req;
      rdok    = rd_req && !mempty;
      reload  = rd_req && mempty && cmd_echo && stalled;
      bnd     = frame_pulse || synth_frame;
      hit     = cmd_host_shock || (track_det && !cmd_jump_busy) || (rot_shock && cmd_rot_en)
                || (synth_frame && !frame_pulse && !mseen);
      chk("R2", "state", int'(state_o), ms);
      chk("R5", "shock_det", int'(shock_det), int'(ms == 7));
      chk("R3", "wr_ptr", int'(wr_ptr), mwr);
      chk("R10", "rd_ptr", int'(rd_ptr), mrd);
      chk("R4", "full", int'(full), int'(mfull));
      chk("R10", "empty", int'(empty), int'(mempty));
      chk("R4", "fill_en", int'(fill_en), int'(filling && !mfull));
      chk("R4", "hold", int'(hold), int'(ms == 4));
      chk("R3", "wr_en", int'(wr_en), int'(wrok));
      chk("R10", "rd_en", int'(rd_en), int'(rdok));
      ns = ms;
      if (cmd_flush || bypass) ns = 0;
      else case (ms)
         0: ns = 6;
         6: ns = hit ? 7 : (wrok ? 1 : 6);
         1: ns = hit ? 7 : (mfull ? 4 : 1);
         2: ns = hit ? 7 : (mfull ? 4 : (bnd ? 1 : 2));
         4: ns = hit ? 7 : (cmd_pfb ? 5 : 4);
         7: ns = cmd_pfb ? 5 : ((mempty && !cmd_echo) ? 0 : 7);
         5: ns = 2;
         default: ns = 0;
      endcase
      if (ns == 0) begin
         nwr = 0; nrd = 0; nsave = 0; nbase = 0;
      end else begin
         nwr   = (ms == 5) ? msave : (wrok ? mnext(mwr) : mwr);
         nrd   = reload ? mbase : (rdok ? mnext(mrd) : mrd);
         nsave = ((ms == 1 || ms == 2) && bnd) ? mwr : msave;
         nbase = ((ns == 4 || ns == 7) && !stalled) ? mrd : mbase;
      end
      @(posedge clk);
      if (ns == 0 || ns == 5) mseen = 0;
      else if (status_read && mfull) mseen = 1;
      ms = ns; mwr = nwr; mrd = nrd; msave = nsave; mbase = nbase;
      @(negedge clk);
   endtask

   task automatic clear_pulses();
      cmd_flush = 0; cmd_pfb = 0; status_read = 0; frame_pulse = 0; synth_frame = 0;
   endtask

   initial begin
      #(10 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int saved, base_obs, maxwr;
      bit saw_last, wrapped;
      saved = 0; maxwr = 0; saw_last = 0; wrapped = 0;
      repeat (3) @(negedge clk);
      chk("R1", "state in reset", int'(state_o), 0);
      rst_n = 1;
      #1;
      chk("R1", "state after reset", int'(state_o), 0);
      chk("R1", "wr_ptr after reset", int'(wr_ptr), 0);
      chk("R1", "shock after reset", int'(shock_det), 0);
      step();
      chk("R1", "first-nibble state", int'(state_o), 6);

      // fill small buffer until hold, with checkpoints
      for (int i = 0; i < 60 && state_o != 3'd4; i++) begin
         wr_req = 1; rd_req = (i % 3 == 2);
         frame_pulse = (i % 4 == 3); synth_frame = frame_pulse;
         if (frame_pulse && (state_o == 3'd1 || state_o == 3'd2)) saved = int'(wr_ptr);
         if (int'(wr_ptr) > maxwr) maxwr = int'(wr_ptr);
         step();
      end
      clear_pulses(); wr_req = 0; rd_req = 0;
      chk("R4", "hold reached", int'(state_o), 4);
      chk("R12", "small wrap max", int'(maxwr <= DS - 1), 1);
      status_read = 1; step(); status_read = 0;
      synth_frame = 1; step(); synth_frame = 0;
      chk("R6", "missed frame masked after full read", int'(state_o), 4);
      cmd_pfb = 1; step(); cmd_pfb = 0;
      chk("R7", "resume state", int'(state_o), 5);
      step();
      chk("R7", "refill state", int'(state_o), 2);
      chk("R7", "write address restored", int'(wr_ptr), saved);
      frame_pulse = 1; synth_frame = 1; step(); clear_pulses();
      chk("R7", "boundary returns to fill", int'(state_o), 1);

      // track detector, masked then live; echo replay; drain to idle
      cmd_jump_busy = 1; track_det = 1; wr_req = 1; rd_req = 1;
      repeat (3) step();
      chk("R6", "track masked by jump busy", int'(state_o), 1);
      cmd_jump_busy = 0; base_obs = int'(rd_ptr); step();
      chk("R5", "track shock entered", int'(state_o), 7);
      chk("R5", "shock flag", int'(shock_det), 1);
      track_det = 0; cmd_echo = 1; wr_req = 0;
      for (int i = 0; i < 40 && !empty; i++) step();
      step();
      chk("R11", "echo reload of read pointer", int'(rd_ptr), base_obs);
      chk("R11", "still in shock", int'(state_o), 7);
      cmd_echo = 0;
      for (int i = 0; i < 40 && !empty; i++) step();
      step();
      chk("R9", "drain to idle", int'(state_o), 0);
      chk("R9", "pointers cleared", int'(wr_ptr) + int'(rd_ptr), 0);
      rd_req = 0;

      // rotational shock with and without enable
      step(); wr_req = 1; repeat (5) step(); wr_req = 0;
      rot_shock = 1; repeat (2) step();
      chk("R6", "rotation ignored when disabled", int'(state_o), 1);
      cmd_rot_en = 1; step();
      chk("R5", "rotation shock entered", int'(state_o), 7);
      cmd_pfb = 1; step(); cmd_pfb = 0; step(); step();
      chk("R5", "persistent rotation re-enters shock", int'(state_o), 7);
      rot_shock = 0; cmd_rot_en = 0;
      cmd_pfb = 1; step(); cmd_pfb = 0; step();
      chk("R7", "refill after second resume", int'(state_o), 2);

      // host shock, flush, bypass
      wr_req = 1; repeat (3) step(); wr_req = 0;
      cmd_host_shock = 1; step(); cmd_host_shock = 0;
      chk("R5", "host shock", int'(state_o), 7);
      cmd_flush = 1; step(); cmd_flush = 0;
      chk("R8", "flush state", int'(state_o), 0);
      chk("R8", "flush pointers", int'(wr_ptr) + int'(rd_ptr), 0);
      bypass = 1; wr_req = 1; repeat (3) step();
      chk("R8", "bypass holds idle", int'(state_o), 0);
      chk("R8", "bypass blocks fill", int'(fill_en), 0);
      bypass = 0; wr_req = 0; step();
      chk("R8", "bypass exit to first nibble", int'(state_o), 6);
      chk("R8", "bypass exit empty", int'(empty), 1);

      // large memory wrap
      large_mem = 1; cmd_flush = 1; step(); cmd_flush = 0;
      for (int i = 0; i < 50; i++) begin
         wr_req = 1; rd_req = (i % 2 == 1);
         frame_pulse = (i % 8 == 7); synth_frame = frame_pulse;
         if (int'(wr_ptr) == DL - 1) saw_last = 1;
         else if (saw_last && wr_ptr == '0) wrapped = 1;
         step();
      end
      clear_pulses();
      chk("R12", "large wrap point reached", int'(saw_last), 1);
      chk("R12", "large wrap to zero", int'(wrapped), 1);

      // pseudo-random mix
      for (int i = 0; i < 4000; i++) begin
         cmd_flush      = ($urandom_range(199) == 0);
         bypass         = ($urandom_range(299) == 0);
         cmd_pfb        = ($urandom_range(19) == 0);
         cmd_host_shock = ($urandom_range(99) == 0);
         cmd_jump_busy  = ($urandom_range(3) != 0);
         track_det      = ($urandom_range(29) == 0);
         rot_shock      = ($urandom_range(49) == 0);
         if ($urandom_range(99) == 0) cmd_rot_en = ~cmd_rot_en;
         if ($urandom_range(49) == 0) cmd_echo = ~cmd_echo;
         status_read    = ($urandom_range(9) == 0);
         frame_pulse    = ($urandom_range(19) == 0);
         synth_frame    = frame_pulse || ($urandom_range(99) == 0);
         wr_req         = ($urandom_range(9) < 7);
         rd_req         = ($urandom_range(9) < 4);
         step();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule